// File: doc/BRIEF.md
# Page-Oriented Clock Pattern Sequencer

This block plays back pages of 64-bit pattern words held in an internal pattern memory. Bits 63 to 16 of each word drive 48 digital clock outputs. Bits 6 to 0 give the word's own dwell time, counted in time-base ticks, and bit 15 marks the last word of a page. The pattern data therefore sets the playback timing; there is no fixed word rate.

A host loads the memory through a simple write port while the sequencer is idle. A start pulse names the first address of a page, and playback then walks consecutive addresses. A page ends at the first word with its end flag set, or after 128 words. At a page end the sequencer either stops, which clears the clock outputs and pulses `done`, or restarts at the page's first address when loop mode is on. The tick period is a parameter given in clock cycles, so a 50 ns tick can be derived from the system clock.

Top module: `clkpat_seq`

## Requirements
- R1: After reset, `busy` is 0, `done` is 0 and `clk_out` is all-zero.
- R2: A start pulse in idle is sampled on a clock edge. From the next cycle `busy` is 1 and `clk_out` equals bits 63:16 of the word at `start_addr`. Each later word of the page is shown in turn from consecutive addresses.
- R3: A word whose dwell field (bits 6:0) holds N, with N at most 69, stays on `clk_out` for exactly (N+1) ticks. One tick is TICK_CYCLES clock cycles.
- R4: A dwell field of 70 or more (up to 127) holds its word for exactly 70 ticks.
- R5: When the word with bit 15 set has run for its full dwell, and loop mode is off, `clk_out` returns to all-zero and `busy` falls in the same cycle. `done` is 1 for exactly that one cycle.
- R6: A page with no end flag ends after its 128th word, whatever the memory holds beyond it.
- R7: If `loop_en` is 1 when a page ends, playback goes on without a gap from the page's start address. `busy` stays 1 and `done` stays 0. The page ends normally at the first end that sees `loop_en` at 0.
- R8: A start pulse while `busy` is 1 is ignored. The running page's sequence and timing do not change, and `start_addr` is not taken up.
- R9: A write presented while `busy` is 1 leaves the memory unchanged. Writes presented in idle are stored.
- R10: Page addresses advance modulo the memory depth, so a page that runs past the last address continues at address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Host write strobe for the pattern memory |
| wr_addr | input | ADDR_W | Host write address |
| wr_data | input | 64 | Host write data (pattern word) |
| start | input | 1 | Start request; taken only when idle |
| start_addr | input | ADDR_W | First address of the page to play |
| loop_en | input | 1 | Repeat the page at its end instead of stopping |
| busy | output | 1 | High while a page is playing |
| done | output | 1 | One-cycle pulse when playback stops |
| clk_out | output | 48 | Digital clock outputs (bits 63:16 of the active word) |

## Verification
The bench builds the block with ADDR_W = 8 and TICK_CYCLES = 2. The 256-word memory then lets a 130-word unterminated page show the 128-word limit, and lets a page cross the top address and wrap. The two-cycle tick keeps even 70-tick clamped words short, and still shows that each duration is a whole multiple of the tick. Loop mode, a start and a write arriving during playback, and dwell values 0, 69, 70 and 127 are each driven against a scoreboard of expected words and durations.

// File: rtl/clkpat_pkg.sv
package clkpat_pkg;

    localparam int WORD_W    = 64;
    localparam int CLK_LSB   = 16;
    localparam int CLK_W     = WORD_W - CLK_LSB;
    localparam int DWELL_W   = 7;
    localparam int END_BIT   = 15;
    localparam int MAX_TICKS = 70;
    localparam int PAGE_MAX  = 128;
    localparam int IDX_W     = $clog2(PAGE_MAX);

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_PLAY = 1'b1
    } seq_state_e;

    // dwell field N holds a word for N+1 ticks, limited to MAX_TICKS
    function automatic logic [DWELL_W-1:0] dwell_ticks(input logic [DWELL_W-1:0] n);
        if (n >= DWELL_W'(MAX_TICKS - 1))
            return DWELL_W'(MAX_TICKS);
        else
            return n + DWELL_W'(1);
    endfunction

endpackage

// File: rtl/clkpat_tick_gen.sv
module clkpat_tick_gen #(
    parameter int TICK_CYCLES = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    output logic tick
);

    generate
        if (TICK_CYCLES <= 1) begin : g_every
            assign tick = 1'b1;
        end else begin : g_count
            localparam int CNT_W = $clog2(TICK_CYCLES);
            localparam logic [CNT_W-1:0] LAST = CNT_W'(TICK_CYCLES - 1);

            logic [CNT_W-1:0] cnt_d, cnt_q;

            always_comb begin
                if (clr || cnt_q == LAST)
                    cnt_d = '0;
                else
                    cnt_d = cnt_q + CNT_W'(1);
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    cnt_q <= '0;
                else
                    cnt_q <= cnt_d;
            end

            assign tick = (cnt_q == LAST);

            // R3
            tick_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
                cnt_q <= LAST);

            // R3
            tick_sparse_chk: assert property (@(posedge clk) disable iff (!rst_n)
                tick && !clr |=> !tick);
        end
    endgenerate

endmodule

// File: rtl/clkpat_pattern_mem.sv
module clkpat_pattern_mem
    import clkpat_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [WORD_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [WORD_W-1:0] rdata
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [WORD_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we)
            mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];

endmodule

// File: rtl/clkpat_play_ctrl.sv
module clkpat_play_ctrl
    import clkpat_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic              loop_en,
    input  logic              tick,
    input  logic [WORD_W-1:0] rd_word,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              tick_clr,
    output logic              busy,
    output logic              done,
    output logic [CLK_W-1:0]  clk_out
);

    typedef struct packed {
        seq_state_e         state;
        logic [ADDR_W-1:0]  base;
        logic [IDX_W-1:0]   idx;
        logic [DWELL_W-1:0] rem;
        logic               last;
        logic [CLK_W-1:0]   pat;
        logic               done;
    } ctl_t;

    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(PAGE_MAX - 1);

    ctl_t ctl_d, ctl_q;
    logic page_end;
    logic word_over;

    assign page_end  = ctl_q.last || (ctl_q.idx == IDX_LAST);
    assign word_over = tick && (ctl_q.rem == DWELL_W'(1));

    always_comb begin
        if (ctl_q.state == ST_IDLE)
            rd_addr = start_addr;
        else if (page_end)
            rd_addr = ctl_q.base;
        else
            rd_addr = ctl_q.base + ADDR_W'(ctl_q.idx) + ADDR_W'(1);
    end

    always_comb begin
        ctl_d      = ctl_q;
        ctl_d.done = 1'b0;
        tick_clr   = 1'b0;
        unique case (ctl_q.state)
            ST_IDLE: begin
                if (start) begin
                    tick_clr    = 1'b1;
                    ctl_d.state = ST_PLAY;
                    ctl_d.base  = start_addr;
                    ctl_d.idx   = '0;
                    ctl_d.rem   = dwell_ticks(rd_word[DWELL_W-1:0]);
                    ctl_d.last  = rd_word[END_BIT];
                    ctl_d.pat   = rd_word[WORD_W-1:CLK_LSB];
                end
            end
            ST_PLAY: begin
                if (tick && !word_over) begin
                    ctl_d.rem = ctl_q.rem - DWELL_W'(1);
                end else if (word_over) begin
                    if (page_end && !loop_en) begin
                        ctl_d.state = ST_IDLE;
                        ctl_d.idx   = '0;
                        ctl_d.rem   = '0;
                        ctl_d.last  = 1'b0;
                        ctl_d.pat   = '0;
                        ctl_d.done  = 1'b1;
                    end else begin
                        ctl_d.idx  = page_end ? '0 : ctl_q.idx + IDX_W'(1);
                        ctl_d.rem  = dwell_ticks(rd_word[DWELL_W-1:0]);
                        ctl_d.last = rd_word[END_BIT];
                        ctl_d.pat  = rd_word[WORD_W-1:CLK_LSB];
                    end
                end
            end
            default: ctl_d = ctl_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '{state: ST_IDLE, base: '0, idx: '0, rem: '0,
                       last: 1'b0, pat: '0, done: 1'b0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign busy    = (ctl_q.state == ST_PLAY);
    assign done    = ctl_q.done;
    assign clk_out = ctl_q.pat;

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (clk_out == '0));

    // R5
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy)));

    // R4
    dwell_clamp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (ctl_q.rem >= DWELL_W'(1) && ctl_q.rem <= DWELL_W'(MAX_TICKS)));

    // R3
    dwell_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy && !word_over |=> $stable(clk_out));

    // R8
    start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy && start |=> $stable(ctl_q.base));

    // R6
    page_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy && word_over && ctl_q.idx == IDX_LAST |=> (ctl_q.idx == '0));

endmodule

// File: rtl/clkpat_seq.sv
module clkpat_seq
    import clkpat_pkg::*;
#(
    parameter int ADDR_W      = 10,
    parameter int TICK_CYCLES = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [63:0]       wr_data,
    input  logic              start,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic              loop_en,
    output logic              busy,
    output logic              done,
    output logic [47:0]       clk_out
);

    logic              tick;
    logic              tick_clr;
    logic              mem_we;
    logic [ADDR_W-1:0] rd_addr;
    logic [WORD_W-1:0] rd_word;

    // host writes only land while no page is playing
    assign mem_we = wr_en && !busy;

    clkpat_tick_gen #(
        .TICK_CYCLES (TICK_CYCLES)
    ) tick_i (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (tick_clr),
        .tick  (tick)
    );

    clkpat_pattern_mem #(
        .ADDR_W (ADDR_W)
    ) mem_i (
        .clk   (clk),
        .we    (mem_we),
        .waddr (wr_addr),
        .wdata (wr_data),
        .raddr (rd_addr),
        .rdata (rd_word)
    );

    clkpat_play_ctrl #(
        .ADDR_W (ADDR_W)
    ) ctrl_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .start_addr (start_addr),
        .loop_en    (loop_en),
        .tick       (tick),
        .rd_word    (rd_word),
        .rd_addr    (rd_addr),
        .tick_clr   (tick_clr),
        .busy       (busy),
        .done       (done),
        .clk_out    (clk_out)
    );

    // R2
    start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy && start |=> busy);

endmodule

// File: tb/clkpat_seq_tb_top.sv
module clkpat_seq_tb_top;

    localparam int AW    = 8;
    localparam int DEPTH = 1 << AW;
    localparam int TC    = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [63:0]   wr_data = '0;
    logic          start = 1'b0;
    logic [AW-1:0] start_addr = '0;
    logic          loop_en = 1'b0;
    logic          busy;
    logic          done;
    logic [47:0]   clk_out;

    always #2 clk = ~clk;

    clkpat_seq #(.ADDR_W(AW), .TICK_CYCLES(TC)) dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .start(start), .start_addr(start_addr),
        .loop_en(loop_en), .busy(busy), .done(done), .clk_out(clk_out)
    );

    typedef struct {
        logic [47:0] pat;
        int          cyc;
        bit          is_end;
        string       req;
    } exp_t;

    exp_t        sb[$];
    logic [63:0] model [DEPTH];
    int          n_chk = 0;
    int          n_fail = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic int ticks_of(input logic [6:0] n);
        return (n >= 7'd69) ? 70 : int'(n) + 1;
    endfunction

    function automatic logic [63:0] mkword(input logic [47:0] pat, input logic [6:0] dw,
                                           input bit last);
        return {pat, last, 8'h00, dw};
    endfunction

    task automatic host_write(input int a, input logic [63:0] w, input bit upd);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = AW'(a); wr_data = w;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
        if (upd) model[a % DEPTH] = w;
    endtask

    // driver: push the expected page (passes times), then the end marker
    task automatic expect_page(input int base, input int passes, input string req);
        for (int p = 0; p < passes; p++) begin
            for (int i = 0; i < 128; i++) begin
                exp_t e;
                logic [63:0] w;
                w = model[(base + i) % DEPTH];
                e.pat = w[63:16]; e.cyc = ticks_of(w[6:0]) * TC;
                e.is_end = 1'b0; e.req = req;
                sb.push_back(e);
                if (w[15]) break;
            end
        end
        begin
            exp_t e;
            e.pat = '0; e.cyc = 0; e.is_end = 1'b1; e.req = "R5";
            sb.push_back(e);
        end
    endtask

    task automatic pulse_start(input int a, input bit expect_taken);
        @(negedge clk);
        start = 1'b1; start_addr = AW'(a);
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        if (expect_taken)
            check(busy == 1'b1, "R2", "busy after start", longint'(busy), 1);
    endtask

    task automatic wait_idle();
        int guard;
        guard = 0;
        while ((busy || sb.size() != 0) && guard < 20000) begin
            @(negedge clk);
            guard++;
        end
        repeat (3) @(negedge clk);
    endtask

    // monitor: compares every busy cycle against the scoreboard head
    exp_t        cur;
    bit          have_cur = 1'b0;
    int          left = 0;
    bit          bad = 1'b0;
    logic [47:0] bad_val = '0;
    bit          prev_busy = 1'b0;
    bit          want_done_low = 1'b0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (want_done_low) begin
                check(done == 1'b0, "R5", "done width", longint'(done), 0);
                want_done_low = 1'b0;
            end
            if (busy) begin
                if (!have_cur) begin
                    if (sb.size() == 0) begin
                        check(1'b0, "R8", "unexpected playback", longint'(clk_out), 0);
                    end else begin
                        cur = sb.pop_front();
                        if (cur.is_end) begin
                            check(1'b0, cur.req, "busy past page end", 1, 0);
                        end else begin
                            have_cur = 1'b1; left = cur.cyc; bad = 1'b0;
                        end
                    end
                end
                if (have_cur) begin
                    if (clk_out !== cur.pat && !bad) begin
                        bad = 1'b1; bad_val = clk_out;
                    end
                    left--;
                    if (left == 0) begin
                        check(!bad, cur.req, "word value/duration",
                              longint'(bad_val), longint'(cur.pat));
                        have_cur = 1'b0;
                    end
                end
            end else if (prev_busy) begin
                if (have_cur) begin
                    check(1'b0, cur.req, "word cut short", longint'(left), 0);
                    have_cur = 1'b0;
                end
                if (sb.size() != 0 && sb[0].is_end) begin
                    cur = sb.pop_front();
                    check(done == 1'b1 && clk_out == '0, cur.req, "page end done/clk_out",
                          longint'({done, clk_out}), longint'({1'b1, 48'h0}));
                    want_done_low = 1'b1;
                end else begin
                    check(1'b0, "R5", "page ended early", longint'(sb.size()), 0);
                end
            end
            prev_busy = busy;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        for (int i = 0; i < DEPTH; i++) model[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1
        check(busy == 1'b0, "R1", "busy at reset", longint'(busy), 0);
        check(done == 1'b0, "R1", "done at reset", longint'(done), 0);
        check(clk_out == '0, "R1", "clk_out at reset", longint'(clk_out), 0);

        // R2 R3: basic page, assorted dwell values
        host_write(0, mkword(48'h0000_0000_0001, 7'd0, 1'b0), 1);
        host_write(1, mkword(48'hA5A5_0000_FFFF, 7'd1, 1'b0), 1);
        host_write(2, mkword(48'h8000_0000_0000, 7'd3, 1'b0), 1);
        host_write(3, mkword(48'h0123_4567_89AB, 7'd69, 1'b0), 1);
        host_write(4, mkword(48'hFFFF_FFFF_FFFF, 7'd2, 1'b1), 1);
        host_write(5, mkword(48'hDEAD_BEEF_0000, 7'd5, 1'b0), 1);
        expect_page(0, 1, "R2 R3");
        pulse_start(0, 1);
        wait_idle();

        // R4: clamped dwell values
        host_write(20, mkword(48'h0F0F_0F0F_0F0F, 7'd70, 1'b0), 1);
        host_write(21, mkword(48'h0000_1111_0000, 7'd127, 1'b0), 1);
        host_write(22, mkword(48'h7777_0000_7777, 7'd100, 1'b1), 1);
        expect_page(20, 1, "R4");
        pulse_start(20, 1);
        wait_idle();

        // R6: 130 words with no end flag
        for (int i = 0; i < 130; i++)
            host_write(100 + i, mkword(48'(i + 1) << (i % 40), 7'd0, 1'b0), 1);
        expect_page(100, 1, "R6");
        pulse_start(100, 1);
        wait_idle();

        // R7: loop mode, two passes then stop
        host_write(40, mkword(48'h0000_0000_0C0C, 7'd2, 1'b0), 1);
        host_write(41, mkword(48'h3030_0000_0000, 7'd4, 1'b0), 1);
        host_write(42, mkword(48'h0000_5A5A_0000, 7'd1, 1'b1), 1);
        expect_page(40, 2, "R7");
        loop_en = 1'b1;
        pulse_start(40, 1);
        repeat (((3 + 5 + 2) * TC) + 2) @(posedge clk);
        @(negedge clk);
        loop_en = 1'b0;
        wait_idle();

        // R8 R9: start and write during playback are ignored
        expect_page(0, 1, "R8");
        pulse_start(0, 1);
        repeat (4) @(negedge clk);
        pulse_start(20, 0);
        host_write(3, mkword(48'hBAD0_BAD0_BAD0, 7'd0, 1'b1), 0);
        wait_idle();
        // R9: replay shows original memory contents
        expect_page(0, 1, "R9");
        pulse_start(0, 1);
        wait_idle();

        // R10: page crossing the top address
        for (int i = 0; i < 10; i++)
            host_write((250 + i) % DEPTH,
                       mkword(48'hC000_0000_0000 | 48'(i * 3 + 1), 7'(i % 3), i == 9), 1);
        expect_page(250, 1, "R10");
        pulse_start(250, 1);
        wait_idle();

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule